// File: doc/BRIEF.md
# Dual-Port Inter-Processor Mailbox

This block joins two processors, called side A and side B, that run from one shared clock. Each side has its own register port. Through that port a side reads and writes a control register, a status register and a bank of data channels. A word that one side writes into outgoing channel n is held for the other side. The other side reads it from incoming channel n. Per-channel status bits tell the sender when the slot is free again, and tell the receiver when a word is waiting.

Each side can also ring a doorbell on the other side. The request stays raised until the partner acknowledges it by clearing its pending bit. A side can post a 3-bit flag value to its partner. A two-stage handshake carries that value, and during the transfer the sender sees an update-pending bit. Each side also shows the power mode of its partner and drives one interrupt line, which the local enable bits gate.

Register map, as a 3-bit word address: 0 is control, 1 is status, and 4+n is data channel n. A write to 4+n fills outgoing channel n. A read of 4+n returns incoming channel n and frees that channel.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, both control registers read 0, and both status registers read 0x00F0_0000: every channel-empty bit is set and every other bit is clear. Both interrupt outputs are 0.
- R2: A write on one side to channel n (address 4+n) has these effects after one clock edge. The writer's status clears its empty bit at position 23−n. The partner's status sets its full bit at position 27−n. The partner reads the written word at address 4+n.
- R3: When the receiving side reads address 4+n while its full bit is set, that full bit clears at the next edge and the sender's empty bit 23−n is set again.
- R4: A write to a channel whose empty bit is clear is ignored: the word held for the partner does not change.
- R5: Writing 1 to control bit 19−n raises status bit 31−n (doorbell pending) on the partner one edge later. Control bit 19−n reads 1 until the partner clears that pending bit, and writing 0 to control bit 19−n does not clear it.
- R6: Writing 1 to status bit 31−n clears that pending bit and the partner's control request bit 19−n together. Writing 0 to that bit changes nothing.
- R7: The 3-bit flag field is control bits [2:0]. A control write starts its transfer, and the value reaches the partner's status bits [2:0] after two edges. The sender's status bit 8 (update pending) is 1 for those two edges and clears in the same edge in which the partner first shows the new value.
- R8: While status bit 8 is 1, the flag field of a control write is ignored. The sender's control [2:0] keeps the earlier value, and that earlier value is what reaches the partner.
- R9: Status bits [13:12] show the partner's power-mode input, coded as run=0, wait=1, stop=2, deep-sleep=3.
- R10: A side's interrupt output is high exactly when at least one of these pairs is set: empty bit 23−n together with enable bit 23−n, full bit 27−n together with enable bit 27−n, or doorbell pending bit 31−n together with enable bit 31−n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_wr_en | input | 1 | Side A register write strobe |
| a_rd_en | input | 1 | Side A register read strobe |
| a_addr | input | 3 | Side A word address |
| a_wdata | input | DW | Side A write data |
| a_rdata | output | DW | Side A read data (combinational) |
| a_pmode | input | 2 | Power mode of side A, shown to side B |
| a_irq | output | 1 | Side A interrupt |
| b_wr_en | input | 1 | Side B register write strobe |
| b_rd_en | input | 1 | Side B register read strobe |
| b_addr | input | 3 | Side B word address |
| b_wdata | input | DW | Side B write data |
| b_rdata | output | DW | Side B read data (combinational) |
| b_pmode | input | 2 | Power mode of side B, shown to side A |
| b_irq | output | 1 | Side B interrupt |

## Verification
On every cycle, the assertions check the following:
- a write to a free channel fills it;
- a write to a filled channel leaves the held word untouched;
- reading a filled channel empties it;
- a doorbell request never drops without an acknowledge from the partner;
- the flag update-pending window is exactly two cycles long.

Only the bench's scenarios show the remaining behaviour:
- the exact bit positions seen through the register ports;
- the data values that arrive on the far side;
- the power-mode field;
- the interrupt gating;
- the rule that a flag write during a pending transfer is dropped while the earlier value still arrives.

// File: rtl/ipc_mb_pkg.sv
package ipc_mb_pkg;
  localparam int REG_W     = 32;
  localparam int ADR_W     = 3;
  localparam int FLAG_W    = 3;
  localparam int MAX_CH    = 4;
  localparam int DATA_BASE = 4;

  // descending per-channel field tops (channel n sits at TOP - n)
  localparam int DBELL_TOP = 31;  // status: doorbell pending, ctrl: doorbell enable
  localparam int FULL_TOP  = 27;  // status: full, ctrl: full enable
  localparam int EMPTY_TOP = 23;  // status: empty, ctrl: empty enable
  localparam int RING_TOP  = 19;  // ctrl: doorbell request

  localparam int FBUSY_BIT = 8;
  localparam int PM_LO     = 12;

  localparam logic [ADR_W-1:0] ADR_CTRL = 3'd0;
  localparam logic [ADR_W-1:0] ADR_STAT = 3'd1;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_WAIT  = 2'd1,
    PM_STOP  = 2'd2,
    PM_DEEP  = 2'd3
  } pmode_e;
endpackage

// File: rtl/ipc_mb_lane.sv
module ipc_mb_lane
  import ipc_mb_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    wr,
  input  logic [DW-1:0]     wdata,
  input  logic [NCH-1:0]    rd,
  output logic [NCH*DW-1:0] data,
  output logic [NCH-1:0]    full
);
  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic          load;
    logic          full_d, full_q;
    logic [DW-1:0] word_q;

    assign load = wr[n] & ~full_q;

    always_comb begin
      full_d = full_q;
      if (load)               full_d = 1'b1;
      else if (rd[n] && full_q) full_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) full_q <= 1'b0;
      else        full_q <= full_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    word_q <= '0;
      else if (load) word_q <= wdata;
    end

    assign full[n]            = full_q;
    assign data[n*DW +: DW]   = word_q;
  end
endmodule

// File: rtl/ipc_mb_flag_xfer.sv
module ipc_mb_flag_xfer
  import ipc_mb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FLAG_W-1:0] val,
  output logic              busy,
  output logic [FLAG_W-1:0] far_flags
);
  logic              go;
  logic              pend_d, pend_q;
  logic              stg1_q, stg2_q;
  logic [FLAG_W-1:0] hold_q, out_q;

  assign go = start & ~pend_q;

  always_comb begin
    pend_d = pend_q;
    if (go)          pend_d = 1'b1;
    else if (stg2_q) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      stg1_q <= 1'b0;
      stg2_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      stg1_q <= go;
      stg2_q <= stg1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  hold_q <= '0;
    else if (go) hold_q <= val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (stg2_q) out_q <= hold_q;
  end

  assign busy      = pend_q;
  assign far_flags = out_q;
endmodule

// File: rtl/ipc_mb_side.sv
module ipc_mb_side
  import ipc_mb_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADR_W-1:0]  addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [1:0]        far_pm,
  output logic              irq,
  output logic [NCH-1:0]    tx_wr,
  input  logic [NCH-1:0]    tx_empty,
  output logic [NCH-1:0]    rx_rd,
  input  logic [NCH*DW-1:0] rx_data,
  input  logic [NCH-1:0]    rx_full,
  output logic [NCH-1:0]    ring_out,
  input  logic [NCH-1:0]    dbell_in,
  output logic [NCH-1:0]    dbell_clr_out,
  input  logic [NCH-1:0]    ring_clr_in,
  output logic              flag_start,
  output logic [FLAG_W-1:0] flag_val,
  input  logic              flag_busy,
  input  logic [FLAG_W-1:0] flag_rx
);
  logic              ctrl_wr, stat_wr;
  logic [NCH-1:0]    w_den, w_fen, w_een, w_ring, w_ack;
  logic [NCH-1:0]    den_d, den_q, fen_d, fen_q, een_d, een_q;
  logic [NCH-1:0]    ring_d, ring_q;
  logic [FLAG_W-1:0] flag_d, flag_q;
  logic              flag_en;
  logic [REG_W-1:0]  ctrl_img, stat_img;

  assign ctrl_wr = wr_en && (addr == ADR_CTRL);
  assign stat_wr = wr_en && (addr == ADR_STAT);
  assign flag_en = ctrl_wr && !flag_busy;

  always_comb begin
    for (int n = 0; n < NCH; n++) begin
      w_den[n]  = wdata[DBELL_TOP - n];
      w_fen[n]  = wdata[FULL_TOP - n];
      w_een[n]  = wdata[EMPTY_TOP - n];
      w_ring[n] = wdata[RING_TOP - n];
      w_ack[n]  = wdata[DBELL_TOP - n];
      tx_wr[n]  = wr_en && (addr == ADR_W'(DATA_BASE + n));
      rx_rd[n]  = rd_en && (addr == ADR_W'(DATA_BASE + n));
    end
  end

  // next-state
  always_comb begin
    den_d  = ctrl_wr ? w_den : den_q;
    fen_d  = ctrl_wr ? w_fen : fen_q;
    een_d  = ctrl_wr ? w_een : een_q;
    ring_d = (ring_q & ~ring_clr_in) | (ctrl_wr ? w_ring : '0);
    flag_d = flag_en ? wdata[FLAG_W-1:0] : flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      den_q  <= '0;
      fen_q  <= '0;
      een_q  <= '0;
      ring_q <= '0;
      flag_q <= '0;
    end else begin
      den_q  <= den_d;
      fen_q  <= fen_d;
      een_q  <= een_d;
      ring_q <= ring_d;
      flag_q <= flag_d;
    end
  end

  assign ring_out      = ring_q;
  assign dbell_clr_out = stat_wr ? w_ack : '0;
  assign flag_start    = ctrl_wr;
  assign flag_val      = wdata[FLAG_W-1:0];

  always_comb begin
    ctrl_img = '0;
    stat_img = '0;
    for (int n = 0; n < NCH; n++) begin
      ctrl_img[DBELL_TOP - n] = den_q[n];
      ctrl_img[FULL_TOP - n]  = fen_q[n];
      ctrl_img[EMPTY_TOP - n] = een_q[n];
      ctrl_img[RING_TOP - n]  = ring_q[n];
      stat_img[DBELL_TOP - n] = dbell_in[n];
      stat_img[FULL_TOP - n]  = rx_full[n];
      stat_img[EMPTY_TOP - n] = tx_empty[n];
    end
    ctrl_img[FLAG_W-1:0]   = flag_q;
    stat_img[FLAG_W-1:0]   = flag_rx;
    stat_img[FBUSY_BIT]    = flag_busy;
    stat_img[PM_LO +: 2]   = far_pm;
  end

  always_comb begin
    rdata = '0;
    if (addr == ADR_CTRL)      rdata[REG_W-1:0] = ctrl_img;
    else if (addr == ADR_STAT) rdata[REG_W-1:0] = stat_img;
    for (int n = 0; n < NCH; n++)
      if (addr == ADR_W'(DATA_BASE + n)) rdata = rx_data[n*DW +: DW];
  end

  assign irq = |((dbell_in & den_q) | (rx_full & fen_q) | (tx_empty & een_q));
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mb_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_wr_en,
  input  logic             a_rd_en,
  input  logic [2:0]       a_addr,
  input  logic [DW-1:0]    a_wdata,
  output logic [DW-1:0]    a_rdata,
  input  logic [1:0]       a_pmode,
  output logic             a_irq,
  input  logic             b_wr_en,
  input  logic             b_rd_en,
  input  logic [2:0]       b_addr,
  input  logic [DW-1:0]    b_wdata,
  output logic [DW-1:0]    b_rdata,
  input  logic [1:0]       b_pmode,
  output logic             b_irq
);
  initial begin
    if (NCH < 1 || NCH > MAX_CH) $error("NCH out of range");
    if (DW < REG_W)              $error("DW below register width");
  end

  logic [NCH-1:0]    ab_wr, ab_rd, ab_full, ba_wr, ba_rd, ba_full;
  logic [NCH*DW-1:0] ab_data, ba_data;
  logic [NCH-1:0]    a_ring, b_ring, a_ack, b_ack;
  logic              ab_fstart, ba_fstart, ab_fbusy, ba_fbusy;
  logic [FLAG_W-1:0] ab_fval, ba_fval, ab_fout, ba_fout;

  ipc_mb_lane #(.NCH(NCH), .DW(DW)) lane_ab_i (
    .clk(clk), .rst_n(rst_n), .wr(ab_wr), .wdata(a_wdata), .rd(ab_rd),
    .data(ab_data), .full(ab_full)
  );

  ipc_mb_lane #(.NCH(NCH), .DW(DW)) lane_ba_i (
    .clk(clk), .rst_n(rst_n), .wr(ba_wr), .wdata(b_wdata), .rd(ba_rd),
    .data(ba_data), .full(ba_full)
  );

  ipc_mb_flag_xfer flag_ab_i (
    .clk(clk), .rst_n(rst_n), .start(ab_fstart), .val(ab_fval),
    .busy(ab_fbusy), .far_flags(ab_fout)
  );

  ipc_mb_flag_xfer flag_ba_i (
    .clk(clk), .rst_n(rst_n), .start(ba_fstart), .val(ba_fval),
    .busy(ba_fbusy), .far_flags(ba_fout)
  );

  ipc_mb_side #(.NCH(NCH), .DW(DW)) side_a_i (
    .clk(clk), .rst_n(rst_n), .wr_en(a_wr_en), .rd_en(a_rd_en), .addr(a_addr),
    .wdata(a_wdata), .rdata(a_rdata), .far_pm(b_pmode), .irq(a_irq),
    .tx_wr(ab_wr), .tx_empty(~ab_full), .rx_rd(ba_rd), .rx_data(ba_data),
    .rx_full(ba_full), .ring_out(a_ring), .dbell_in(b_ring),
    .dbell_clr_out(a_ack), .ring_clr_in(b_ack), .flag_start(ab_fstart),
    .flag_val(ab_fval), .flag_busy(ab_fbusy), .flag_rx(ba_fout)
  );

  ipc_mb_side #(.NCH(NCH), .DW(DW)) side_b_i (
    .clk(clk), .rst_n(rst_n), .wr_en(b_wr_en), .rd_en(b_rd_en), .addr(b_addr),
    .wdata(b_wdata), .rdata(b_rdata), .far_pm(a_pmode), .irq(b_irq),
    .tx_wr(ba_wr), .tx_empty(~ba_full), .rx_rd(ab_rd), .rx_data(ab_data),
    .rx_full(ab_full), .ring_out(b_ring), .dbell_in(a_ring),
    .dbell_clr_out(b_ack), .ring_clr_in(a_ack), .flag_start(ba_fstart),
    .flag_val(ba_fval), .flag_busy(ba_fbusy), .flag_rx(ab_fout)
  );
endmodule

// File: rtl/ipc_mb_chk.sv
module ipc_mb_chk #(
  parameter int NCH = 4,
  parameter int DW  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    ab_wr,
  input logic [NCH-1:0]    ab_rd,
  input logic [NCH-1:0]    ab_full,
  input logic [NCH*DW-1:0] ab_data,
  input logic [NCH-1:0]    a_ring,
  input logic [NCH-1:0]    b_ack,
  input logic              ab_fbusy
);
  for (genvar n = 0; n < NCH; n++) begin : g_c
    // R2
    fill_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ab_wr[n] && !ab_full[n]) |=> ab_full[n]);
    // R4
    held_word_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ab_wr[n] && ab_full[n]) |=> $stable(ab_data[n*DW +: DW]));
    // R3
    drain_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ab_rd[n] && ab_full[n]) |=> !ab_full[n]);
    // R5
    ring_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_ring[n] && !b_ack[n]) |=> a_ring[n]);
  end

  // R7
  fbusy_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ab_fbusy) |=> ab_fbusy);
  // R7
  fbusy_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_fbusy && $past(ab_fbusy)) |=> !ab_fbusy);
endmodule

bind ipc_mailbox ipc_mb_chk #(.NCH(NCH), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ab_wr(ab_wr), .ab_rd(ab_rd), .ab_full(ab_full),
  .ab_data(ab_data), .a_ring(a_ring), .b_ack(b_ack), .ab_fbusy(ab_fbusy)
);

// File: tb/ipc_mailbox_tb_top.sv
`timescale 1ns/1ps
module ipc_mailbox_tb_top;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          a_wr_en, a_rd_en, b_wr_en, b_rd_en;
  logic [2:0]    a_addr, b_addr;
  logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic [1:0]    a_pmode, b_pmode;
  logic          a_irq, b_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  ipc_mailbox #(.NCH(4), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_wr_en(a_wr_en), .a_rd_en(a_rd_en), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_pmode(a_pmode), .a_irq(a_irq),
    .b_wr_en(b_wr_en), .b_rd_en(b_rd_en), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_pmode(b_pmode), .b_irq(b_irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // all register tasks start and end at a falling edge; each takes one cycle
  task automatic wr(input bit side_b, input logic [2:0] ad, input logic [31:0] d);
    if (side_b) begin b_wr_en = 1; b_addr = ad; b_wdata = d; end
    else        begin a_wr_en = 1; a_addr = ad; a_wdata = d; end
    @(negedge clk);
    a_wr_en = 0; b_wr_en = 0;
  endtask

  task automatic rd(input bit side_b, input logic [2:0] ad, output logic [31:0] d);
    if (side_b) begin b_rd_en = 1; b_addr = ad; end
    else        begin a_rd_en = 1; a_addr = ad; end
    #1 d = side_b ? b_rdata : a_rdata;
    @(negedge clk);
    a_rd_en = 0; b_rd_en = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, 3'd0, v); chk("R1 a ctrl", v, 32'h0);
    rd(1, 3'd0, v); chk("R1 b ctrl", v, 32'h0);
    rd(0, 3'd1, v); chk("R1 a stat", v, 32'h00F0_0000);
    rd(1, 3'd1, v); chk("R1 b stat", v, 32'h00F0_0000);
    chk("R1 irqs", {30'd0, a_irq, b_irq}, 32'h0);
  endtask

  task automatic t_data();
    logic [31:0] v;
    wr(0, 3'd6, 32'hDEAD_BEEF);
    rd(0, 3'd1, v); chk("R2 a empty2 clear", {31'd0, v[21]}, 32'h0);
    rd(1, 3'd1, v); chk("R2 b full2 set", {31'd0, v[25]}, 32'h1);
    rd(1, 3'd6, v); chk("R2 b rx2 word", v, 32'hDEAD_BEEF);
    rd(1, 3'd1, v); chk("R3 b full2 cleared", {31'd0, v[25]}, 32'h0);
    rd(0, 3'd1, v); chk("R3 a empty2 restored", {31'd0, v[21]}, 32'h1);
    wr(1, 3'd4, 32'h1234_5678);
    rd(0, 3'd1, v); chk("R2 a full0 set", {31'd0, v[27]}, 32'h1);
    rd(1, 3'd1, v); chk("R2 b empty0 clear", {31'd0, v[23]}, 32'h0);
    rd(0, 3'd4, v); chk("R2 a rx0 word", v, 32'h1234_5678);
    rd(1, 3'd1, v); chk("R3 b empty0 restored", {31'd0, v[23]}, 32'h1);
  endtask

  task automatic t_full();
    logic [31:0] v;
    wr(0, 3'd5, 32'h0000_1111);
    wr(0, 3'd5, 32'h0000_2222);
    rd(1, 3'd5, v); chk("R4 held word kept", v, 32'h0000_1111);
    rd(1, 3'd5, v); chk("R4 drained slot unchanged", v, 32'h0000_1111);
    rd(1, 3'd1, v); chk("R3 full1 clear after read", {31'd0, v[26]}, 32'h0);
  endtask

  task automatic t_door();
    logic [31:0] v;
    wr(0, 3'd0, 32'h0004_0000);
    rd(1, 3'd1, v); chk("R5 b pending1", {31'd0, v[30]}, 32'h1);
    wr(0, 3'd0, 32'h0);
    rd(0, 3'd0, v); chk("R5 a ring1 held after 0 write", {31'd0, v[18]}, 32'h1);
    wr(1, 3'd1, 32'h0);
    rd(1, 3'd1, v); chk("R6 zero write keeps pending", {31'd0, v[30]}, 32'h1);
    wr(1, 3'd1, 32'h4000_0000);
    rd(1, 3'd1, v); chk("R6 b pending1 cleared", {31'd0, v[30]}, 32'h0);
    rd(0, 3'd0, v); chk("R6 a ring1 accepted", {31'd0, v[18]}, 32'h0);
  endtask

  task automatic t_pmode();
    logic [31:0] v;
    a_pmode = 2'd2; b_pmode = 2'd3;
    rd(1, 3'd1, v); chk("R9 b sees a stop", {30'd0, v[13:12]}, 32'd2);
    rd(0, 3'd1, v); chk("R9 a sees b deep", {30'd0, v[13:12]}, 32'd3);
    a_pmode = 2'd1;
    rd(1, 3'd1, v); chk("R9 b sees a wait", {30'd0, v[13:12]}, 32'd1);
    a_pmode = 2'd0; b_pmode = 2'd0;
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(1, 3'd0, 32'h0200_0000);
    chk("R10 b irq idle", {31'd0, b_irq}, 32'h0);
    wr(0, 3'd6, 32'hCAFE_0002);
    chk("R10 b irq on full2", {31'd0, b_irq}, 32'h1);
    rd(1, 3'd6, v);
    chk("R10 b irq after drain", {31'd0, b_irq}, 32'h0);
    wr(0, 3'd0, 32'h0080_0000);
    chk("R10 a irq on empty0", {31'd0, a_irq}, 32'h1);
    wr(0, 3'd0, 32'h0);
    chk("R10 a irq masked", {31'd0, a_irq}, 32'h0);
    wr(1, 3'd0, 32'h1000_0000);
    wr(0, 3'd0, 32'h0001_0000);
    chk("R10 b irq on doorbell3", {31'd0, b_irq}, 32'h1);
    wr(1, 3'd1, 32'h1000_0000);
    chk("R10 b irq after ack", {31'd0, b_irq}, 32'h0);
    wr(1, 3'd0, 32'h0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_flag();
    logic [31:0] v;
    wr(0, 3'd0, 32'h5);
    rd(0, 3'd1, v); chk("R7 a busy after write", {31'd0, v[8]}, 32'h1);
    rd(1, 3'd1, v); chk("R7 b flags old at +1", {29'd0, v[2:0]}, 32'h0);
    rd(1, 3'd1, v); chk("R7 b flags new at +2", {29'd0, v[2:0]}, 32'h5);
    rd(0, 3'd1, v); chk("R7 a busy cleared", {31'd0, v[8]}, 32'h0);
    wr(0, 3'd0, 32'h6);
    wr(0, 3'd0, 32'h3);
    repeat (4) @(negedge clk);
    rd(1, 3'd1, v); chk("R8 b keeps first value", {29'd0, v[2:0]}, 32'h6);
    rd(0, 3'd0, v); chk("R8 a ctrl flags kept", {29'd0, v[2:0]}, 32'h6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    a_wr_en = 0; a_rd_en = 0; a_addr = '0; a_wdata = '0; a_pmode = 2'd0;
    b_wr_en = 0; b_rd_en = 0; b_addr = '0; b_wdata = '0; b_pmode = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_data();
    t_full();
    t_door();
    t_pmode();
    t_irq();
    t_flag();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule